// File: doc/BRIEF.md
# Reference-Offset Motion Wake Detector

This block takes a stream of three-axis signed acceleration samples and, when its reference mode is switched on, freezes a snapshot of the orientation at that moment. From then on each accepted sample leaves the block as the per-axis difference between the sample and that snapshot. The subtraction saturates, and no filtering is applied. While the mode is off, samples pass through unchanged.

A wake-up detector watches the difference data. An axis counts as moved when the magnitude of its difference is above a 6-bit threshold scaled up into the data width. If any axis has moved on more consecutive samples than a 2-bit duration allows, the interrupt rises. It falls on the first sample that brings every axis back within the threshold of the snapshot. This makes it usable as a displacement alarm: the interrupt means the device is away from the orientation it held when the mode was enabled.

Top module: `hpref_wake_top`

## Requirements
- R1: During and right after reset, `out_valid`, `wake_irq` and all three difference outputs are 0.
- R2: In the cycle where `ref_mode` is high and was low in the previous cycle, the snapshot is taken. It is the sample on the inputs if `smp_valid` is high in that cycle, and otherwise the last sample accepted with `smp_valid`. A sample accepted in the capture cycle itself therefore yields all-zero differences.
- R3: `out_valid` is high exactly one cycle after each cycle with `smp_valid` high. In reference mode, the difference outputs then carry sample minus snapshot per axis. Axis X is `smp_x`, Y is `smp_y`, Z is `smp_z`.
- R4: A difference outside the signed DATA_W range is clamped. With the defaults this is to -32768 below and 32767 above.
- R5: While `ref_mode` is low, each accepted sample appears unchanged on the difference outputs. The interrupt is low one cycle after any cycle with `ref_mode` low, and the duration count is cleared.
- R6: An axis exceeds the threshold when the absolute value of its clamped difference is strictly greater than `wk_ths` shifted left by DATA_W-1-6 bits (512 per step with the defaults). One exceeding axis out of three is enough.
- R7: In reference mode, each accepted sample that exceeds the threshold adds one to a run count, which saturates. On such a sample `wake_irq` goes high, with the same latency as the data, once the run count is greater than `wk_dur`. With `wk_dur` = 0, the first exceeding sample raises it.
- R8: An accepted sample in reference mode on which no axis exceeds the threshold clears the run count and drops `wake_irq` one cycle later.
- R9: In a cycle without `smp_valid`, the difference outputs, the interrupt and the run count hold their values. The one exception is the clearing of R5.
- R10: While `ref_mode` stays high, the snapshot does not change. Taking it low and high again captures a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is on the axis inputs |
| smp_x | input | DATA_W | X axis sample, two's complement |
| smp_y | input | DATA_W | Y axis sample, two's complement |
| smp_z | input | DATA_W | Z axis sample, two's complement |
| ref_mode | input | 1 | Reference mode enable; its rising edge takes the snapshot |
| wk_ths | input | 6 | Wake threshold in coarse steps |
| wk_dur | input | 2 | Number of exceeding samples tolerated before the interrupt |
| out_valid | output | 1 | Difference outputs were updated this cycle |
| diff_x | output | DATA_W | X difference (or raw X with the mode off) |
| diff_y | output | DATA_W | Y difference (or raw Y with the mode off) |
| diff_z | output | DATA_W | Z difference (or raw Z with the mode off) |
| wake_irq | output | 1 | Displacement interrupt, level |

## Verification
The assertions take the inputs to be two-state and steady between clock edges. They also take `ref_mode` to be low throughout reset, so that the first enable after reset is seen as a rising edge. The bench drives every input on the falling edge and holds `ref_mode` and the samples at zero while reset is active. Outside reset it changes `wk_ths` and `wk_dur` freely, because the block samples them only together with an accepted sample. Directed sequences place samples exactly on the threshold boundary, at the extremes of the data range, and on enable edges with and without a coincident sample. A long random phase then toggles the mode and leaves gaps between samples.

// File: rtl/hpref_pkg.sv
package hpref_pkg;
    // number of acceleration axes handled side by side
    localparam int NAXIS = 3;
    // field widths of the wake programming inputs
    localparam int THS_W = 6;
    localparam int DUR_W = 2;
endpackage

// File: rtl/hpref_capture.sv
module hpref_capture
    import hpref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_valid,
    input  logic [NAXIS*DATA_W-1:0]   smp,
    input  logic                      mode,
    output logic [NAXIS*DATA_W-1:0]   ref_eff
);
    localparam int VW = NAXIS * DATA_W;

    typedef struct packed {
        logic [VW-1:0] snap;
        logic [VW-1:0] last;
        logic          mode_p;
    } cap_t;

    cap_t cap_d, cap_q;
    logic rise;

    always_comb begin
        cap_d  = cap_q;
        rise   = mode & ~cap_q.mode_p;
        if (rise) begin
            cap_d.snap = smp_valid ? smp : cap_q.last;
        end
        if (smp_valid) begin
            cap_d.last = smp;
        end
        cap_d.mode_p = mode;
        ref_eff      = cap_d.snap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // R10: with the mode high and already high, the snapshot is kept
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && cap_q.mode_p) |=> $stable(cap_q.snap));

    // R2: a capture cycle with a sample loads that sample as snapshot
    p_snap_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !cap_q.mode_p && smp_valid) |=> (cap_q.snap == $past(smp)));

endmodule

// File: rtl/hpref_diff.sv
module hpref_diff
    import hpref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      mode,
    input  logic [NAXIS*DATA_W-1:0]   smp,
    input  logic [NAXIS*DATA_W-1:0]   ref_eff,
    input  logic [THS_W-1:0]          ths,
    output logic [NAXIS*DATA_W-1:0]   dif,
    output logic                      exceed_any
);
    localparam int SHIFT = DATA_W - 1 - THS_W;
    localparam int WW    = DATA_W + 1;

    logic [WW-1:0]    ths_scaled;
    logic [NAXIS-1:0] exceed;

    always_comb begin
        ths_scaled = {{(WW-THS_W){1'b0}}, ths} << SHIFT;
    end

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        logic [DATA_W-1:0] s_a;
        logic [DATA_W-1:0] r_a;
        logic [WW-1:0]     wide;
        logic [DATA_W-1:0] sat_a;
        logic [DATA_W-1:0] out_a;
        logic [WW-1:0]     mag;

        always_comb begin
            s_a  = smp[a*DATA_W +: DATA_W];
            r_a  = ref_eff[a*DATA_W +: DATA_W];
            wide = {s_a[DATA_W-1], s_a} - {r_a[DATA_W-1], r_a};
            if (wide[WW-1] != wide[WW-2]) begin
                sat_a = wide[WW-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                   : {1'b0, {(DATA_W-1){1'b1}}};
            end else begin
                sat_a = wide[DATA_W-1:0];
            end
            out_a = mode ? sat_a : s_a;
            if (out_a[DATA_W-1]) begin
                mag = ~{1'b1, out_a} + 1'b1;
            end else begin
                mag = {1'b0, out_a};
            end
            exceed[a] = mag > ths_scaled;
        end

        assign dif[a*DATA_W +: DATA_W] = out_a;
    end

    assign exceed_any = |exceed;

endmodule

// File: rtl/hpref_wake.sv
module hpref_wake
    import hpref_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             mode,
    input  logic             exceed_any,
    input  logic [DUR_W-1:0] dur,
    output logic             irq
);
    localparam int CNT_W = DUR_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             irq;
    } wake_t;

    wake_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (!mode) begin
            wk_d = '0;
        end else if (smp_valid) begin
            if (exceed_any) begin
                if (wk_q.run != {CNT_W{1'b1}}) begin
                    wk_d.run = wk_q.run + 1'b1;
                end
                wk_d.irq = wk_d.run > CNT_W'(dur);
            end else begin
                wk_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign irq = wk_q.irq;

    // R7: the interrupt only rises on an exceeding sample in reference mode
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_q.irq) |-> $past(smp_valid && mode && exceed_any));

    // R8: a quiet sample in reference mode drops the interrupt
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode && !exceed_any) |=> (!wk_q.irq && wk_q.run == '0));

    // R5: mode off clears the interrupt
    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !wk_q.irq);

    // R9: no sample in reference mode leaves the run count alone
    p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && mode) |=> $stable(wk_q));

endmodule

// File: rtl/hpref_wake_top.sv
module hpref_wake_top
    import hpref_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_x,
    input  logic signed [DATA_W-1:0] smp_y,
    input  logic signed [DATA_W-1:0] smp_z,
    input  logic                     ref_mode,
    input  logic [THS_W-1:0]         wk_ths,
    input  logic [DUR_W-1:0]         wk_dur,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] diff_x,
    output logic signed [DATA_W-1:0] diff_y,
    output logic signed [DATA_W-1:0] diff_z,
    output logic                     wake_irq
);
    localparam int VW = NAXIS * DATA_W;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] dat;
    } out_t;

    out_t          out_d, out_q;
    logic [VW-1:0] smp_vec;
    logic [VW-1:0] ref_eff;
    logic [VW-1:0] dif_vec;
    logic          exceed_any;

    assign smp_vec = {smp_z, smp_y, smp_x};

    hpref_capture #(.DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp       (smp_vec),
        .mode      (ref_mode),
        .ref_eff   (ref_eff)
    );

    hpref_diff #(.DATA_W(DATA_W)) i_diff (
        .mode       (ref_mode),
        .smp        (smp_vec),
        .ref_eff    (ref_eff),
        .ths        (wk_ths),
        .dif        (dif_vec),
        .exceed_any (exceed_any)
    );

    hpref_wake i_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .mode       (ref_mode),
        .exceed_any (exceed_any),
        .dur        (wk_dur),
        .irq        (wake_irq)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = smp_valid;
        if (smp_valid) begin
            out_d.dat = dif_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign diff_x    = out_q.dat[0*DATA_W +: DATA_W];
    assign diff_y    = out_q.dat[1*DATA_W +: DATA_W];
    assign diff_z    = out_q.dat[2*DATA_W +: DATA_W];

    // R3: output strobe follows the input strobe by one cycle
    p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    p_valid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);

    // R9: outputs hold while no new data
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(diff_x) && $stable(diff_y) && $stable(diff_z)));

    // R2: a sample on the enable edge is its own reference
    p_zero_on_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ref_mode && !$past(ref_mode)) |=>
            (diff_x == '0 && diff_y == '0 && diff_z == '0 && !wake_irq));

    // R5: with the mode off the sample is passed as is
    p_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ref_mode) |=>
            (diff_x == $past(smp_x) && diff_y == $past(smp_y) && diff_z == $past(smp_z)));

endmodule

// File: tb/test_hpref_wake_top.sv
module test_hpref_wake_top;
    localparam int DATA_W = 16;
    localparam int SHIFT  = DATA_W - 1 - 6;
    localparam int SMAX   = 32767;
    localparam int SMIN   = -32768;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     smp_valid = 1'b0;
    logic signed [DATA_W-1:0] smp_x = '0;
    logic signed [DATA_W-1:0] smp_y = '0;
    logic signed [DATA_W-1:0] smp_z = '0;
    logic                     ref_mode = 1'b0;
    logic [5:0]               wk_ths = '0;
    logic [1:0]               wk_dur = '0;
    logic                     out_valid;
    logic signed [DATA_W-1:0] diff_x;
    logic signed [DATA_W-1:0] diff_y;
    logic signed [DATA_W-1:0] diff_z;
    logic                     wake_irq;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural model state
    int m_ref[3];
    int m_last[3];
    int m_d[3];
    int m_en_p = 0;
    int m_cnt  = 0;
    int m_irq  = 0;
    int m_ov   = 0;

    always #2 clk = ~clk;

    hpref_wake_top #(.DATA_W(DATA_W)) i_hpref_wake_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_x     (smp_x),
        .smp_y     (smp_y),
        .smp_z     (smp_z),
        .ref_mode  (ref_mode),
        .wk_ths    (wk_ths),
        .wk_dur    (wk_dur),
        .out_valid (out_valid),
        .diff_x    (diff_x),
        .diff_y    (diff_y),
        .diff_z    (diff_z),
        .wake_irq  (wake_irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic model(input bit v, input int s0, input int s1, input int s2, input bit en);
        int s[3];
        bit ex;
        int lim;
        s[0] = s0; s[1] = s1; s[2] = s2;
        if (en && m_en_p == 0) begin
            for (int a = 0; a < 3; a++) m_ref[a] = v ? s[a] : m_last[a];
        end
        if (v) for (int a = 0; a < 3; a++) m_last[a] = s[a];
        m_en_p = en ? 1 : 0;
        m_ov = v ? 1 : 0;
        ex = 1'b0;
        lim = int'(wk_ths) * (1 << SHIFT);
        if (v) begin
            for (int a = 0; a < 3; a++) begin
                m_d[a] = en ? clamp(s[a] - m_ref[a]) : s[a];
                if ((m_d[a] < 0 ? -m_d[a] : m_d[a]) > lim) ex = 1'b1;
            end
        end
        if (!en) begin
            m_cnt = 0; m_irq = 0;
        end else if (v) begin
            if (ex) begin
                if (m_cnt < 7) m_cnt++;
                m_irq = (m_cnt > int'(wk_dur)) ? 1 : 0;
            end else begin
                m_cnt = 0; m_irq = 0;
            end
        end
    endtask

    task automatic step(input bit v, input int x, input int y, input int z,
                        input bit en, input string tag);
        smp_valid = v;
        smp_x = DATA_W'(x);
        smp_y = DATA_W'(y);
        smp_z = DATA_W'(z);
        ref_mode = en;
        @(posedge clk);
        model(v, x, y, z, en);
        @(negedge clk);
        check(int'(out_valid) == m_ov, tag, "out_valid", int'(out_valid), m_ov);
        check(int'(diff_x) == m_d[0], tag, "diff_x", int'(diff_x), m_d[0]);
        check(int'(diff_y) == m_d[1], tag, "diff_y", int'(diff_y), m_d[1]);
        check(int'(diff_z) == m_d[2], tag, "diff_z", int'(diff_z), m_d[2]);
        check(int'(wake_irq) == m_irq, tag, "wake_irq", int'(wake_irq), m_irq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 3; a++) begin
            m_ref[a] = 0; m_last[a] = 0; m_d[a] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check(diff_x == '0 && diff_y == '0 && diff_z == '0, "R1", "diff", int'(diff_x), 0);
        check(wake_irq == 1'b0, "R1", "wake_irq", int'(wake_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && wake_irq == 1'b0, "R1", "after release", int'(out_valid), 0);

        wk_ths = 6'd4;
        wk_dur = 2'd0;
        // R5: pass-through with the mode off, no interrupt even for large values
        step(1, 1000, -2000, 16000, 0, "R5");
        step(1, 30000, -30000, 5, 0, "R5");
        // R2: enable edge without a sample takes the last accepted sample
        step(0, 7, 7, 7, 1, "R2");
        step(1, 30100, -29900, 5, 1, "R2");
        // R4: saturation both ways, also raises the interrupt (R7 with dur 0)
        step(1, SMIN, SMAX, 5, 1, "R4");
        check(diff_x == 16'sh8000 && diff_y == 16'sh7fff, "R4", "clamp", int'(diff_x), SMIN);
        // R8: back at reference drops the interrupt
        step(1, 30000, -30000, 5, 1, "R8");
        // R6: exactly at threshold (2048) does not count, one above does
        step(1, 30000 + 2048, -30000 - 2048, 5 + 2048, 1, "R6");
        check(wake_irq == 1'b0, "R6", "at limit", int'(wake_irq), 0);
        step(1, 30000, -30000 - 2049, 5, 1, "R6");
        check(wake_irq == 1'b1, "R6", "one axis over", int'(wake_irq), 1);
        step(1, 30000, -30000, 5 + 2049, 1, "R6");
        // R7: duration 2 needs three exceeding samples in a row
        wk_ths = 6'd1;
        wk_dur = 2'd2;
        step(1, 30000, -30000, 5, 1, "R8");
        step(1, 31000, -30000, 5, 1, "R7");
        step(1, 31000, -30000, 5, 1, "R7");
        step(1, 30000, -30000, 5, 1, "R8");
        step(1, 31000, -30000, 5, 1, "R7");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 31000, -30000, 5, 1, "R7");
        step(0, 1, 2, 3, 1, "R9");
        check(wake_irq == 1'b0, "R7", "two samples", int'(wake_irq), 0);
        step(1, 31000, -30000, 5, 1, "R7");
        check(wake_irq == 1'b1, "R7", "third sample", int'(wake_irq), 1);
        // R9: idle cycles hold everything
        step(0, 123, 456, 789, 1, "R9");
        step(0, -1, -1, -1, 1, "R9");
        check(diff_x == 16'sd1000 && out_valid == 1'b0, "R9", "held", int'(diff_x), 1000);
        // R10: snapshot kept while the mode stays high
        step(1, 100, 100, 100, 1, "R10");
        // R5: mode off clears the interrupt and passes raw data
        step(1, 500, 600, 700, 0, "R5");
        check(wake_irq == 1'b0, "R5", "irq cleared", int'(wake_irq), 0);
        // R2: enable edge with a sample gives zero difference
        step(1, -5, -6, -7, 1, "R2");
        check(diff_x == '0 && diff_y == '0 && diff_z == '0, "R2", "zero", int'(diff_x), 0);
        step(1, 0, 0, 0, 1, "R10");
        check(diff_z == 16'sd7, "R10", "new snapshot", int'(diff_z), 7);

        // R3: random sweep across modes, gaps, thresholds and durations
        for (int i = 0; i < 400; i++) begin
            bit v;
            bit en;
            if (i % 37 == 0) wk_ths = 6'($urandom_range(0, 63));
            if (i % 23 == 0) wk_dur = 2'($urandom_range(0, 3));
            v  = ($urandom_range(0, 3) != 0);
            en = (i % 53) > 4;
            if (i % 3 == 0) begin
                step(v, int'($urandom_range(0, 65535)) - 32768,
                        int'($urandom_range(0, 65535)) - 32768,
                        int'($urandom_range(0, 65535)) - 32768, en, "R3");
            end else begin
                step(v, int'($urandom_range(0, 8000)) - 4000,
                        int'($urandom_range(0, 8000)) - 4000,
                        int'($urandom_range(0, 8000)) - 4000, en, "R3");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule